// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block watches one received Ethernet frame at a time as nibbles arrive from the media interface. It counts the nibbles, records any receive-error indication seen while data is valid, and latches a code-error mark. When the frame-end strobe arrives, it combines the length with the side results supplied by neighbouring logic. These side results are the CRC verdict, the address-match verdict, a control-frame mark and a receive-overrun abort. From them it produces a keep/discard decision, a status flag vector for the packet's first descriptor, and the frame length in bytes.

Size classes are decided against a fixed 64-byte minimum and a programmable maximum. A long frame is either jabber or oversize, depending on whether it carries an error. A short frame is either a fragment or undersize on the same basis. Four enable inputs let software keep frames that would otherwise be dropped. These cover error frames, undersized frames, control frames and frames that matched no address. A frame aborted by overrun is always dropped.

The result appears for one cycle, one clock after the frame-end strobe. The nibble counter and the code-error mark are cleared by the same strobe, so the next frame starts clean.

Top module: `rx_frame_classifier`

## Requirements
- R1: After reset, `res_valid`, `res_keep`, `res_flags` and `res_len` are all zero.
- R2: `res_valid` pulses for exactly one cycle, one clock after `frm_end`. `res_len` is the number of nibbles with `nib_valid` high since the previous `frm_end`, divided by two and rounded down. Input `nib_valid` is never high in a `frm_end` cycle.
- R3: The nibble counter stops at its all-ones value of `LEN_W+2` bits and does not wrap. A frame of 70000 nibbles with the default `LEN_W=14` therefore reports length 32767 and is classed as long.
- R4: Let long mean length > `cfg_max_len` and short mean length < 64. Flag bit 0 (jabber) is long with a bad CRC or a code error. Bit 1 (oversize) is long without either. Bit 2 (fragment) is short with a bad CRC or a code error. Bit 3 (undersize) is short without either.
- R5: Flag bit 4 (code error) is set when `phy_rx_err` was high in any cycle in which `nib_valid` was high during the frame.
- R6: With `crc_ok` low, flag bit 5 (alignment) is set if the nibble count is odd, and flag bit 6 (CRC error) is set if it is even.
- R7: A frame with any of flag bits 0, 1, 2, 4, 5 or 6 set is kept only when `keep_err` is high.
- R8: A frame with flag bit 3 set is kept only when `keep_short` is high.
- R9: Flag bit 7 copies `is_ctrl`, and such a frame is kept only when `keep_ctrl` is high.
- R10: Flag bit 8 (no match) is set when `addr_hit` is low, and such a frame is kept only when `keep_all` is high.
- R11: Flag bit 9 copies `rx_overrun`, and such a frame is always discarded whatever the enables are.
- R12: A frame's code-error mark and length do not carry into the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_len | input | LEN_W | Largest legal frame length in bytes |
| keep_err | input | 1 | Keep frames carrying error flags |
| keep_short | input | 1 | Keep undersized frames |
| keep_ctrl | input | 1 | Keep control frames |
| keep_all | input | 1 | Keep frames matching no address |
| nib_valid | input | 1 | One received nibble this cycle |
| phy_rx_err | input | 1 | Receive error from the PHY |
| frm_end | input | 1 | Frame-end strobe, side results valid |
| crc_ok | input | 1 | CRC check passed |
| addr_hit | input | 1 | Destination address matched |
| is_ctrl | input | 1 | Frame is a control frame |
| rx_overrun | input | 1 | Frame aborted by receive overrun |
| res_valid | output | 1 | Result strobe |
| res_keep | output | 1 | 1 keeps the frame, 0 discards it |
| res_flags | output | 10 | Status flags, bit map in R4 to R11 |
| res_len | output | LEN_W+1 | Frame length in bytes |

## Verification
The main sweep sends frames whose byte lengths sit just below, at and just above the 64-byte minimum and the programmed maximum. Each length is sent with both even and odd nibble counts, good and bad CRC, and with and without a receive error. This separates jabber from oversize, fragment from undersize, and alignment from plain CRC error. Every such frame is repeated under each combination of the error and short enables, so that a wrong discard rule shows up against the flag that should gate it. Separate runs step through control and address-miss frames under all sixteen enable settings, send an overrun frame with everything enabled, push one frame past counter saturation, and follow a code-error frame with a clean one.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int FLAG_N   = 10;
  localparam int F_JABBER = 0;
  localparam int F_OVER   = 1;
  localparam int F_FRAG   = 2;
  localparam int F_UNDER  = 3;
  localparam int F_CODE   = 4;
  localparam int F_ALIGN  = 5;
  localparam int F_CRC    = 6;
  localparam int F_CTRL   = 7;
  localparam int F_NOHIT  = 8;
  localparam int F_OVRUN  = 9;

  typedef logic [FLAG_N-1:0] flags_t;

  // Build the status vector from the size verdicts and the side results.
  function automatic flags_t rxfc_flags(input logic is_long, input logic is_short,
                                        input logic bad_crc, input logic odd,
                                        input logic code, input logic ctrl,
                                        input logic hit, input logic ovr);
    flags_t f;
    logic   bad;
    bad = bad_crc | code;
    f = '0;
    f[F_JABBER] = is_long & bad;
    f[F_OVER]   = is_long & ~bad;
    f[F_FRAG]   = is_short & bad;
    f[F_UNDER]  = is_short & ~bad;
    f[F_CODE]   = code;
    f[F_ALIGN]  = bad_crc & odd;
    f[F_CRC]    = bad_crc & ~odd;
    f[F_CTRL]   = ctrl;
    f[F_NOHIT]  = ~hit;
    f[F_OVRUN]  = ovr;
    return f;
  endfunction

  // Each rejecting flag needs its own enable; overrun always rejects.
  function automatic logic rxfc_keep(input flags_t f, input logic k_err,
                                     input logic k_short, input logic k_ctrl,
                                     input logic k_all);
    logic errs;
    errs = f[F_JABBER] | f[F_OVER] | f[F_FRAG] | f[F_CODE] | f[F_ALIGN] | f[F_CRC];
    return ~f[F_OVRUN] & (~errs | k_err) & (~f[F_UNDER] | k_short)
           & (~f[F_CTRL] | k_ctrl) & (~f[F_NOHIT] | k_all);
  endfunction
endpackage

// File: rtl/rxfc_len_counter.sv
module rxfc_len_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_valid,
  input  logic             frm_end,
  output logic [CNT_W-1:0] nib_cnt,
  output logic             cnt_full
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_full = &cnt_q;
  assign nib_cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (frm_end)              cnt_q <= '0;
    else if (nib_valid && !cnt_full) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxfc_err_tracker.sv
module rxfc_err_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic nib_valid,
  input  logic phy_rx_err,
  input  logic frm_end,
  output logic code_seen
);
  logic seen_q;

  assign code_seen = seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        seen_q <= 1'b0;
    else if (frm_end)                  seen_q <= 1'b0;
    else if (nib_valid && phy_rx_err)  seen_q <= 1'b1;
  end
endmodule

// File: rtl/rxfc_decide.sv
module rxfc_decide
  import rxfc_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  localparam int CNT_W  = LEN_W + 2,
  localparam int BYTE_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              keep_err,
  input  logic              keep_short,
  input  logic              keep_ctrl,
  input  logic              keep_all,
  input  logic              frm_end,
  input  logic [CNT_W-1:0]  nib_cnt,
  input  logic              code_seen,
  input  logic              crc_ok,
  input  logic              addr_hit,
  input  logic              is_ctrl,
  input  logic              rx_overrun,
  output logic              res_valid,
  output logic              res_keep,
  output flags_t            res_flags,
  output logic [BYTE_W-1:0] res_len
);
  logic [BYTE_W-1:0] len_bytes;
  logic              is_long;
  logic              is_short;
  flags_t            flags_d;
  logic              keep_d;

  assign len_bytes = nib_cnt[CNT_W-1:1];
  assign is_long   = len_bytes > {1'b0, cfg_max_len};
  assign is_short  = len_bytes < BYTE_W'(MIN_LEN);
  assign flags_d   = rxfc_flags(is_long, is_short, ~crc_ok, nib_cnt[0], code_seen,
                                is_ctrl, addr_hit, rx_overrun);
  assign keep_d    = rxfc_keep(flags_d, keep_err, keep_short, keep_ctrl, keep_all);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_keep  <= 1'b0;
      res_flags <= '0;
      res_len   <= '0;
    end else begin
      res_valid <= frm_end;
      if (frm_end) begin
        res_keep  <= keep_d;
        res_flags <= flags_d;
        res_len   <= len_bytes;
      end
    end
  end
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rxfc_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  localparam int CNT_W  = LEN_W + 2,
  localparam int BYTE_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              keep_err,
  input  logic              keep_short,
  input  logic              keep_ctrl,
  input  logic              keep_all,
  input  logic              nib_valid,
  input  logic              phy_rx_err,
  input  logic              frm_end,
  input  logic              crc_ok,
  input  logic              addr_hit,
  input  logic              is_ctrl,
  input  logic              rx_overrun,
  output logic              res_valid,
  output logic              res_keep,
  output logic [FLAG_N-1:0] res_flags,
  output logic [BYTE_W-1:0] res_len
);
  // Internal events brought out by name for the checker.
  logic [CNT_W-1:0] nib_cnt;
  logic             cnt_full;
  logic             code_seen;

  rxfc_len_counter #(.CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .nib_valid (nib_valid),
    .frm_end   (frm_end),
    .nib_cnt   (nib_cnt),
    .cnt_full  (cnt_full)
  );

  rxfc_err_tracker u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_valid  (nib_valid),
    .phy_rx_err (phy_rx_err),
    .frm_end    (frm_end),
    .code_seen  (code_seen)
  );

  rxfc_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_max_len (cfg_max_len),
    .keep_err    (keep_err),
    .keep_short  (keep_short),
    .keep_ctrl   (keep_ctrl),
    .keep_all    (keep_all),
    .frm_end     (frm_end),
    .nib_cnt     (nib_cnt),
    .code_seen   (code_seen),
    .crc_ok      (crc_ok),
    .addr_hit    (addr_hit),
    .is_ctrl     (is_ctrl),
    .rx_overrun  (rx_overrun),
    .res_valid   (res_valid),
    .res_keep    (res_keep),
    .res_flags   (res_flags),
    .res_len     (res_len)
  );
endmodule

// File: rtl/rxfc_checker.sv
module rxfc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nib_valid,
  input logic             phy_rx_err,
  input logic             frm_end,
  input logic             keep_err,
  input logic [CNT_W-1:0] nib_cnt,
  input logic             cnt_full,
  input logic             code_seen,
  input logic             res_valid,
  input logic             res_keep,
  input logic [9:0]       res_flags
);
  assert_valid_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(frm_end));

  assert_cnt_holds_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_full && !frm_end) |=> cnt_full);

  assert_size_classes_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_flags[3:0]));

  assert_code_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && phy_rx_err && !frm_end) |=> code_seen);

  assert_err_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_keep && (|{res_flags[6:4], res_flags[2:0]})) |-> $past(keep_err));

  assert_overrun_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flags[9]) |-> !res_keep);

  assert_clean_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> (nib_cnt == '0 && !code_seen));
endmodule

bind rx_frame_classifier rxfc_checker #(.CNT_W(CNT_W)) u_rxfc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .nib_valid  (nib_valid),
  .phy_rx_err (phy_rx_err),
  .frm_end    (frm_end),
  .keep_err   (keep_err),
  .nib_cnt    (nib_cnt),
  .cnt_full   (cnt_full),
  .code_seen  (code_seen),
  .res_valid  (res_valid),
  .res_keep   (res_keep),
  .res_flags  (res_flags)
);

// File: tb/rx_frame_classifier_bench.sv
module rx_frame_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 14;
  localparam int MAXLEN     = 80;
  localparam int CNT_TOP    = (1 << (LEN_W + 2)) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LEN_W-1:0]  cfg_max_len = LEN_W'(MAXLEN);
  logic              keep_err = 0, keep_short = 0, keep_ctrl = 0, keep_all = 0;
  logic              nib_valid = 0, phy_rx_err = 0, frm_end = 0;
  logic              crc_ok = 0, addr_hit = 0, is_ctrl = 0, rx_overrun = 0;
  logic              res_valid, res_keep;
  logic [9:0]        res_flags;
  logic [LEN_W:0]    res_len;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_classifier #(.LEN_W(LEN_W)) u_rx_frame_classifier (
    .clk, .rst_n, .cfg_max_len, .keep_err, .keep_short, .keep_ctrl, .keep_all,
    .nib_valid, .phy_rx_err, .frm_end, .crc_ok, .addr_hit, .is_ctrl, .rx_overrun,
    .res_valid, .res_keep, .res_flags, .res_len
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench-side model of the classification, written from the requirements.
  task automatic expect_frame(input int nib, input bit has_er, input bit good, input bit hit,
                              input bit ctrl, input bit ovr,
                              output int e_len, output logic [9:0] e_flags, output bit e_keep);
    int  n;
    bit  lng, sht, faulty, rej_err;
    n       = (nib > CNT_TOP) ? CNT_TOP : nib;
    e_len   = n / 2;
    lng     = e_len > MAXLEN;
    sht     = e_len < 64;
    faulty  = !good || has_er;
    e_flags = '0;
    if (lng)  e_flags[faulty ? 0 : 1] = 1'b1;
    if (sht)  e_flags[faulty ? 2 : 3] = 1'b1;
    e_flags[4] = has_er;
    if (!good) e_flags[(n % 2 == 1) ? 5 : 6] = 1'b1;
    e_flags[7] = ctrl;
    e_flags[8] = !hit;
    e_flags[9] = ovr;
    rej_err = lng || (sht && faulty) || has_er || !good;
    e_keep  = !ovr;
    if (rej_err && !keep_err) e_keep = 0;
    if (sht && !faulty && !keep_short) e_keep = 0;
    if (ctrl && !keep_ctrl) e_keep = 0;
    if (!hit && !keep_all) e_keep = 0;
  endtask

  task automatic run_frame(input int nib, input int er_at, input bit good, input bit hit,
                           input bit ctrl, input bit ovr, input string tag);
    int          e_len;
    logic [9:0]  e_flags;
    bit          e_keep;
    expect_frame(nib, er_at >= 0, good, hit, ctrl, ovr, e_len, e_flags, e_keep);
    for (int i = 0; i < nib; i++) begin
      @(negedge clk);
      nib_valid  = 1'b1;
      phy_rx_err = (i == er_at);
    end
    @(negedge clk);
    nib_valid = 0; phy_rx_err = 0;
    frm_end = 1; crc_ok = good; addr_hit = hit; is_ctrl = ctrl; rx_overrun = ovr;
    @(negedge clk);
    frm_end = 0; crc_ok = 0; addr_hit = 0; is_ctrl = 0; rx_overrun = 0;
    check(res_valid === 1'b1, {"R2 valid ", tag}, res_valid, 1);
    check(res_len === (LEN_W+1)'(e_len), {"R2 R3 length ", tag}, res_len, e_len);
    check(res_flags === e_flags, {"R4 R5 R6 R9 R10 R11 flags ", tag}, res_flags, e_flags);
    check(res_keep === e_keep, {"R7 R8 R9 R10 R11 keep ", tag}, res_keep, e_keep);
    @(negedge clk);
    check(res_valid === 1'b0, {"R2 single pulse ", tag}, res_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lens[7] = '{62, 63, 64, 65, 79, 80, 81};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(res_valid === 0 && res_keep === 0, "R1 reset strobe/keep", {res_valid, res_keep}, 0);
    check(res_flags === 0 && res_len === 0, "R1 reset flags/len", {res_flags, res_len}, 0);

    // Size, CRC, alignment and code sweep under error/short enable combos.
    for (int e = 0; e < 4; e++) begin
      keep_err = e[0]; keep_short = e[1]; keep_ctrl = 0; keep_all = 0;
      foreach (lens[k]) for (int odd = 0; odd < 2; odd++)
        for (int g = 0; g < 2; g++) for (int c = 0; c < 2; c++)
          run_frame(2*lens[k] + odd, c ? 3 : -1, g[0], 1'b1, 1'b0, 1'b0, "R4 R6 R7 R8 sweep");
    end

    // Control and address-miss frames under all enable settings.
    for (int e = 0; e < 16; e++) begin
      {keep_all, keep_ctrl, keep_short, keep_err} = 4'(e);
      for (int cm = 0; cm < 4; cm++)
        run_frame(140, -1, 1'b1, cm[0], cm[1], 1'b0, "R9 R10 enables");
    end

    // Overrun always discarded.
    {keep_all, keep_ctrl, keep_short, keep_err} = 4'hF;
    run_frame(140, -1, 1'b1, 1'b1, 1'b0, 1'b1, "R11 overrun");
    run_frame(141, 5, 1'b0, 1'b0, 1'b1, 1'b1, "R11 overrun with errors");

    // Counter saturation on a very long frame.
    keep_err = 1;
    run_frame(70000, -1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 saturation");

    // Code-error frame followed by a clean frame.
    {keep_all, keep_ctrl, keep_short, keep_err} = 4'h0;
    run_frame(140, 10, 1'b1, 1'b1, 1'b0, 1'b0, "R5 code error");
    run_frame(140, -1, 1'b1, 1'b1, 1'b0, 1'b0, "R12 clean after error");
    check(res_flags[4] === 1'b0, "R12 code mark cleared", res_flags[4], 0);
    run_frame(0, -1, 1'b1, 1'b1, 1'b0, 1'b0, "R12 empty frame length");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule